// File: doc/BRIEF.md
# Pixel Threshold Trim Tuner

This controller sets the 4-bit threshold trim of every pixel in a group, one pixel at a time. For each pixel it writes a starting trim code, then fires a fixed burst of test-charge injections. It counts how many of them the pixel answered. The comparison of that count against half the burst tells the controller whether the pixel fires too often or too rarely. It then nudges the code by a shrinking step and tries again. After four such decisions the code is final: it is written to the pixel one last time and kept in an internal result table.

A run starts with a one-cycle `start_i` pulse. While the run is active, the controller drives three things: the injection strobe, the trim write (pixel index plus code), and a busy flag. It watches a single hit line that the selected pixel's comparator drives. When every pixel has been tuned, a done flag rises and stays high. The tuned code of any pixel can then be read by index. The analog injector and the trim DAC lie outside the block.

Top module: `tt_trim_tuner`

## Requirements
- R1: After reset `done_o`, `busy_o`, `inj_o` and `trim_we_o` are 0 and every entry of the result table reads 0.
- R2: For each pixel, the first trim write of a run carries the mid-code 8, and pixel 0 is written in the cycle after `start_i` is taken.
- R3: Each decision is preceded by exactly 64 injection strobes. Each strobe lasts one cycle, and consecutive strobes are 1+LISTEN_CYC cycles apart (4 by default).
- R4: If the hit count of a decision is above 32 (the pixel fires too often), the code rises by the current step. If it is below 32, the code falls by the current step.
- R5: A count of exactly 32 leaves the code unchanged for that decision.
- R6: Each pixel gets four decisions, with steps 4, 2, 1 and 1, and the code saturates at 15. This gives exactly five trim writes per pixel: the mid-code, one after each of the first three decisions, and a final write after the fourth.
- R7: A pixel's answer is counted at most once per injection, even if the hit line stays high for several cycles of the window. Hits that arrive outside an injection window (during trim writes or while idle) are not counted.
- R8: Pixels are tuned in ascending index order. Each trim write comes before the injections it governs, and a trim write and a strobe never share a cycle.
- R9: After the last pixel's final write, `done_o` is 1 and `busy_o` is 0 until the next start. `rd_code_o` returns the final code of pixel `rd_pix_i` in the same cycle.
- R10: A `start_i` pulse while a run is active has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a tuning run (one-cycle pulse) |
| hit_i | input | 1 | Comparator response of the selected pixel |
| inj_o | output | 1 | Injection strobe, one cycle |
| trim_we_o | output | 1 | Trim register write enable |
| trim_pix_o | output | PIX_W | Pixel index of the trim write |
| trim_code_o | output | TRIM_W | Trim code being written |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | All pixels tuned |
| rd_pix_i | input | PIX_W | Pixel index to read back |
| rd_code_o | output | TRIM_W | Final trim code of `rd_pix_i` |

## Verification
The first trim write appears one cycle after `start_i` is taken. Strobes follow every 1+LISTEN_CYC cycles. A hit must arrive in the strobe cycle or in the listen cycles after it. The decision takes one cycle after the last window, and the next write follows in the cycle after that. A result becomes readable the cycle after the final write. The bench's pixel model answers at the falling edge of each strobe cycle, so the answer falls inside the window. All outputs are logged at falling edges, away from the edge where they change. The per-decision strobe counts, the strobe spacing and the write sequence are checked against these cycle counts once each run ends.

// File: rtl/tt_pkg.sv
package tt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_INJECT,
        ST_LISTEN,
        ST_DECIDE,
        ST_FINAL,
        ST_DONE
    } tt_state_e;

endpackage

// File: rtl/tt_hit_tally.sv
module tt_hit_tally #(
    parameter int INJ_N = 64,
    localparam int CNT_W = $clog2(INJ_N + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             win_open_i,
    input  logic             win_end_i,
    input  logic             hit_i,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        logic             seen;
        logic [CNT_W-1:0] count;
    } tally_t;

    tally_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (clr_i) begin
            nxt_d.seen  = 1'b0;
            nxt_d.count = '0;
        end else if (win_end_i) begin
            // one answer per injection, however long the hit lasts
            if (cur_q.seen || (win_open_i && hit_i)) begin
                nxt_d.count = cur_q.count + CNT_W'(1);
            end
            nxt_d.seen = 1'b0;
        end else if (win_open_i && hit_i) begin
            nxt_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign count_o = cur_q.count;

    a_r7_tally_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> (cur_q.count == $past(cur_q.count)) ||
                   (cur_q.count == $past(cur_q.count) + CNT_W'(1)));

    a_r3_tally_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(cur_q.count) <= INJ_N);

endmodule

// File: rtl/tt_sar_update.sv
module tt_sar_update #(
    parameter int TRIM_W = 4,
    parameter int INJ_N  = 64,
    localparam int CNT_W  = $clog2(INJ_N + 1),
    localparam int ITER_W = (TRIM_W > 1) ? $clog2(TRIM_W) : 1
) (
    input  logic [TRIM_W-1:0] code_i,
    input  logic [ITER_W-1:0] iter_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [TRIM_W-1:0] code_o
);

    localparam int SUM_W = TRIM_W + 1;
    localparam int HALF  = INJ_N / 2;
    localparam int MAXC  = (1 << TRIM_W) - 1;

    logic [SUM_W-1:0] step;
    logic [SUM_W-1:0] wide;
    logic [SUM_W-1:0] up;
    logic [SUM_W-1:0] dn;

    always_comb begin
        // halving steps, the last decision repeats the unit step
        if (int'(iter_i) < TRIM_W - 1) begin
            step = SUM_W'(1 << (TRIM_W - 2 - int'(iter_i)));
        end else begin
            step = SUM_W'(1);
        end
        wide = {1'b0, code_i};
        up   = wide + step;
        dn   = wide - step;
        if (int'(count_i) > HALF) begin
            code_o = (up > SUM_W'(MAXC)) ? TRIM_W'(MAXC) : up[TRIM_W-1:0];
        end else if (int'(count_i) < HALF) begin
            code_o = (wide < step) ? '0 : dn[TRIM_W-1:0];
        end else begin
            code_o = code_i;
        end
    end

endmodule

// File: rtl/tt_code_store.sv
module tt_code_store #(
    parameter int NUM_PIX = 4,
    parameter int TRIM_W  = 4,
    localparam int PIX_W  = (NUM_PIX > 1) ? $clog2(NUM_PIX) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [PIX_W-1:0]  wr_pix_i,
    input  logic [TRIM_W-1:0] wr_code_i,
    input  logic [PIX_W-1:0]  rd_pix_i,
    output logic [TRIM_W-1:0] rd_code_o
);

    logic [NUM_PIX-1:0][TRIM_W-1:0] mem_q, mem_d;

    always_comb begin
        mem_d = mem_q;
        for (int i = 0; i < NUM_PIX; i++) begin
            if (we_i && (int'(wr_pix_i) == i)) begin
                mem_d[i] = wr_code_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    always_comb begin
        rd_code_o = '0;
        for (int i = 0; i < NUM_PIX; i++) begin
            if (int'(rd_pix_i) == i) begin
                rd_code_o = mem_q[i];
            end
        end
    end

    a_r9_store_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_i |=> mem_q == $past(mem_q));

endmodule

// File: rtl/tt_trim_tuner.sv
module tt_trim_tuner
    import tt_pkg::*;
#(
    parameter int NUM_PIX    = 4,
    parameter int TRIM_W     = 4,
    parameter int INJ_N      = 64,
    parameter int LISTEN_CYC = 3,
    localparam int PIX_W     = (NUM_PIX > 1) ? $clog2(NUM_PIX) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              hit_i,
    output logic              inj_o,
    output logic              trim_we_o,
    output logic [PIX_W-1:0]  trim_pix_o,
    output logic [TRIM_W-1:0] trim_code_o,
    output logic              busy_o,
    output logic              done_o,
    input  logic [PIX_W-1:0]  rd_pix_i,
    output logic [TRIM_W-1:0] rd_code_o
);

    localparam int CNT_W  = $clog2(INJ_N + 1);
    localparam int ITER_W = (TRIM_W > 1) ? $clog2(TRIM_W) : 1;
    localparam int INJ_W  = (INJ_N > 1) ? $clog2(INJ_N) : 1;
    localparam int WIN_W  = (LISTEN_CYC > 1) ? $clog2(LISTEN_CYC) : 1;
    localparam logic [TRIM_W-1:0] MID_CODE = TRIM_W'(1 << (TRIM_W - 1));
    localparam int HALF   = INJ_N / 2;

    typedef struct packed {
        tt_state_e         state;
        logic [PIX_W-1:0]  pix;
        logic [ITER_W-1:0] iter;
        logic [TRIM_W-1:0] code;
        logic [INJ_W-1:0]  inj;
        logic [WIN_W-1:0]  win;
    } ctl_t;

    ctl_t cur_q, nxt_d;

    logic              tally_clr;
    logic              win_open;
    logic              win_end;
    logic [CNT_W-1:0]  hit_count;
    logic [TRIM_W-1:0] next_code;
    logic              store_we;

    tt_hit_tally #(
        .INJ_N (INJ_N)
    ) u_tally (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (tally_clr),
        .win_open_i (win_open),
        .win_end_i  (win_end),
        .hit_i      (hit_i),
        .count_o    (hit_count)
    );

    tt_sar_update #(
        .TRIM_W (TRIM_W),
        .INJ_N  (INJ_N)
    ) u_update (
        .code_i  (cur_q.code),
        .iter_i  (cur_q.iter),
        .count_i (hit_count),
        .code_o  (next_code)
    );

    tt_code_store #(
        .NUM_PIX (NUM_PIX),
        .TRIM_W  (TRIM_W)
    ) u_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (store_we),
        .wr_pix_i  (cur_q.pix),
        .wr_code_i (cur_q.code),
        .rd_pix_i  (rd_pix_i),
        .rd_code_o (rd_code_o)
    );

    always_comb begin
        nxt_d     = cur_q;
        tally_clr = 1'b0;
        win_open  = 1'b0;
        win_end   = 1'b0;
        store_we  = 1'b0;
        inj_o     = 1'b0;
        trim_we_o = 1'b0;
        unique case (cur_q.state)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    nxt_d.state = ST_WRITE;
                    nxt_d.pix   = '0;
                    nxt_d.iter  = '0;
                    nxt_d.code  = MID_CODE;
                end
            end
            ST_WRITE: begin
                trim_we_o   = 1'b1;
                tally_clr   = 1'b1;
                nxt_d.inj   = '0;
                nxt_d.state = ST_INJECT;
            end
            ST_INJECT: begin
                inj_o       = 1'b1;
                win_open    = 1'b1;
                nxt_d.win   = '0;
                nxt_d.state = ST_LISTEN;
            end
            ST_LISTEN: begin
                win_open = 1'b1;
                if (cur_q.win == WIN_W'(LISTEN_CYC - 1)) begin
                    win_end = 1'b1;
                    if (cur_q.inj == INJ_W'(INJ_N - 1)) begin
                        nxt_d.state = ST_DECIDE;
                    end else begin
                        nxt_d.inj   = cur_q.inj + INJ_W'(1);
                        nxt_d.state = ST_INJECT;
                    end
                end else begin
                    nxt_d.win = cur_q.win + WIN_W'(1);
                end
            end
            ST_DECIDE: begin
                nxt_d.code = next_code;
                if (cur_q.iter == ITER_W'(TRIM_W - 1)) begin
                    nxt_d.state = ST_FINAL;
                end else begin
                    nxt_d.iter  = cur_q.iter + ITER_W'(1);
                    nxt_d.state = ST_WRITE;
                end
            end
            ST_FINAL: begin
                trim_we_o = 1'b1;
                store_we  = 1'b1;
                if (cur_q.pix == PIX_W'(NUM_PIX - 1)) begin
                    nxt_d.state = ST_DONE;
                end else begin
                    nxt_d.pix   = cur_q.pix + PIX_W'(1);
                    nxt_d.iter  = '0;
                    nxt_d.code  = MID_CODE;
                    nxt_d.state = ST_WRITE;
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q       <= '0;
            cur_q.state <= ST_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign trim_pix_o  = cur_q.pix;
    assign trim_code_o = cur_q.code;
    assign busy_o      = (cur_q.state != ST_IDLE) && (cur_q.state != ST_DONE);
    assign done_o      = (cur_q.state == ST_DONE);

    a_r3_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inj_o |=> !inj_o);

    a_r8_write_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(trim_we_o && inj_o));

    a_r2_start_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> (trim_we_o && (trim_code_o == MID_CODE) && (trim_pix_o == '0)));

    a_r9_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && !inj_o && !trim_we_o));

    a_r5_tie_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_q.state == ST_DECIDE && int'(hit_count) == HALF) |=> (trim_code_o == $past(trim_code_o)));

    a_r10_busy_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_q.state == ST_LISTEN && start_i) |=> busy_o);

endmodule

// File: tb/tt_trim_tuner_tb_top.sv
module tt_trim_tuner_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NP   = 4;
    localparam int TW   = 4;
    localparam int INJ  = 64;
    localparam int LIS  = 3;
    localparam int PW   = 2;
    localparam int NRUN = 3;

    // per run: pixel targets (code at which the pixel answers half the time),
    // expected final codes, and hit-line mode (0 single, 1 stretched, 2 noise at writes)
    localparam int TGT  [NRUN][NP] = '{'{8, 13, 0, 5}, '{16, 3, 7, 11}, '{9, 2, 15, 6}};
    localparam int EXPC [NRUN][NP] = '{'{8, 13, 0, 5}, '{15, 3, 7, 11}, '{9, 2, 15, 6}};
    localparam int MODE [NRUN]     = '{0, 1, 2};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          hit_i = 1'b0;
    logic [PW-1:0] rd_pix_i = '0;
    logic          inj_o, trim_we_o, busy_o, done_o;
    logic [PW-1:0] trim_pix_o;
    logic [TW-1:0] trim_code_o, rd_code_o;

    int errs = 0;
    int checks = 0;
    int run_idx = 0;
    int mode = 0;
    int cyc = 0;
    int k = 0;
    int hold = 0;
    int cur_code = 0;
    int cur_pix = 0;
    int nwr = 0;
    int strobes = 0;
    int last_strobe = 0;
    int gap_bad = 0;
    int wr_code [32];
    int wr_pix  [32];
    int wr_str  [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    tt_trim_tuner #(
        .NUM_PIX    (NP),
        .TRIM_W     (TW),
        .INJ_N      (INJ),
        .LISTEN_CYC (LIS)
    ) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .start_i     (start_i),
        .hit_i       (hit_i),
        .inj_o       (inj_o),
        .trim_we_o   (trim_we_o),
        .trim_pix_o  (trim_pix_o),
        .trim_code_o (trim_code_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .rd_pix_i    (rd_pix_i),
        .rd_code_o   (rd_code_o)
    );

    function automatic int occ(int t, int c);
        int v;
        v = 32 + 8 * (t - c);
        if (v < 0) v = 0;
        if (v > INJ) v = INJ;
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // pixel model and output logger, both at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst_n) begin
                hit_i = 1'b0;
                hold  = 0;
            end else begin
                hit_i = 1'b0;
                if (hold > 0) begin
                    hit_i = 1'b1;
                    hold--;
                end
                if (inj_o) begin
                    if (strobes > 0 && (cyc - last_strobe) != LIS + 1) gap_bad++;
                    last_strobe = cyc;
                    strobes++;
                    if (k < occ(TGT[run_idx][cur_pix], cur_code)) begin
                        hit_i = 1'b1;
                        hold  = (mode == 1) ? 1 : 0;
                    end
                    k++;
                end
                if (trim_we_o) begin
                    if (nwr > 0 && nwr <= 32) wr_str[nwr-1] = strobes;
                    if (nwr < 32) begin
                        wr_code[nwr] = int'(trim_code_o);
                        wr_pix[nwr]  = int'(trim_pix_o);
                    end
                    nwr++;
                    strobes  = 0;
                    k        = 0;
                    cur_code = int'(trim_code_o);
                    cur_pix  = int'(trim_pix_o);
                    if (mode == 2) hit_i = 1'b1;
                end
            end
        end
    end

    task automatic do_run(input int r);
        int n;
        int base;
        int second;
        int bad_pix;
        int bad_str;
        run_idx = r;
        mode    = MODE[r];
        nwr     = 0;
        gap_bad = 0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (!done_o && n < 40000) begin
            @(negedge clk);
            n++;
            if (r == 1 && n == 3000) start_i = 1'b1;
            if (r == 1 && n == 3001) begin
                start_i = 1'b0;
                chk(busy_o == 1'b1, "R10 busy after start in run", int'(busy_o), 1);
            end
        end
        chk(done_o == 1'b1, "R9 done reached (watchdog)", int'(done_o), 1);
        chk(busy_o == 1'b0, "R9 busy low when done", int'(busy_o), 0);
        chk(nwr == NP * 5, "R6 five writes per pixel", nwr, NP * 5);
        chk(gap_bad == 0, "R3 strobe spacing", gap_bad, 0);
        for (int p = 0; p < NP; p++) begin
            base = p * 5;
            bad_pix = 0;
            bad_str = 0;
            for (int w = 0; w < 5; w++) begin
                if (wr_pix[base + w] != p) bad_pix++;
            end
            for (int w = 0; w < 4; w++) begin
                if (wr_str[base + w] != INJ) bad_str++;
            end
            chk(bad_pix == 0, "R8 pixel order", wr_pix[base], p);
            chk(bad_str == 0, "R3 strobes per decision", wr_str[base], INJ);
            chk(wr_code[base] == 8, "R2 mid-code first", wr_code[base], 8);
            second = (TGT[r][p] > 8) ? 12 : ((TGT[r][p] < 8) ? 4 : 8);
            chk(wr_code[base + 1] == second, "R4 R5 first decision", wr_code[base + 1], second);
            chk(wr_code[base + 4] == EXPC[r][p], "R6 R7 final write", wr_code[base + 4], EXPC[r][p]);
            rd_pix_i = PW'(p);
            #1;
            chk(int'(rd_code_o) == EXPC[r][p], "R9 readback", int'(rd_code_o), EXPC[r][p]);
        end
        repeat (5) @(negedge clk);
        chk(done_o == 1'b1 && inj_o == 1'b0, "R9 done held", int'(done_o), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errs++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
        chk(busy_o == 1'b0, "R1 busy after reset", int'(busy_o), 0);
        chk(inj_o == 1'b0 && trim_we_o == 1'b0, "R1 strobe and write idle", int'(inj_o), 0);
        rd_pix_i = PW'(2);
        #1;
        chk(rd_code_o == '0, "R1 table cleared", int'(rd_code_o), 0);

        // vector table walk
        for (int r = 0; r < NRUN; r++) begin
            do_run(r);
        end

        // reset in the middle of a run
        run_idx = 0;
        mode    = 0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (500) @(negedge clk);
        chk(busy_o == 1'b1, "R10 run active before reset", int'(busy_o), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b0 && done_o == 1'b0, "R1 reset mid-run", int'(busy_o), 0);
        rd_pix_i = PW'(1);
        #1;
        chk(rd_code_o == '0, "R1 table cleared mid-run", int'(rd_code_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule